// File: doc/BRIEF.md
# Programmable Video Timing Generator

This block produces the raster timing for a parallel pixel output: horizontal sync, vertical sync, a data-enable strobe and the column and row of the current active pixel. Each axis runs through four phases in a fixed order (active, front porch, sync, back porch). Software sets the length of each phase through a small register write port. Every length is written as the count minus one, so a field of zero means a phase one unit long.

Video runs only while both an output-enable bit and a frame-enable bit are set. The block copies the timing registers into a working set at the first pixel of every frame, so a register write made in the middle of a frame takes effect at the next one. When an enable is cleared, the frame in progress completes and output then halts. A stop-status output stays high until that point, so software can poll it before it issues a software reset. A frame-end event sets a pending flag, which is cleared by writing one. The software reset is self-clearing: a busy flag stays high for a fixed number of cycles, then drops.

Top module: `vtg_top`

## Requirements
- R1: After the reset input is released, hsync_o, vsync_o, de_o, irq_o, pend_o, stop_o and swrst_busy_o are low, and x_o and y_o are zero.
- R2: Control register at address 0 has these bits: bit 0 output enable, bit 1 frame enable, bit 2 software reset, bit 3 interrupt enable. A frame starts only when bits 0 and 1 are both set. The first active pixel appears in the cycle after the clock edge that follows the write edge, and stop_o is high for the whole frame.
- R3: The horizontal length fields are at these addresses: 1 active, 3 front porch, 4 sync, 5 back porch. Each holds the count minus one. A line is active, front porch, sync, back porch in that order, and its length is the sum of the four counts. hsync_o is high only during the sync phase.
- R4: The vertical length fields are at these addresses: 2 active, 6 front porch, 7 sync, 8 back porch. Each holds the count minus one, in lines. Lines follow the same phase order, and vsync_o is high for every pixel of the vertical sync lines.
- R5: de_o is high only when both axes are in their active phase. x_o gives the column inside the active line and y_o gives the row inside the active lines. Each reads zero outside its own active phase.
- R6: Length fields are sampled only at the first pixel of a frame. A write made during a frame changes nothing until the next frame.
- R7: If either enable is cleared during a frame, that frame runs to its last pixel. stop_o falls in the next cycle, and from then on all outputs stay idle.
- R8: pend_o goes high on the edge that ends each frame. irq_o equals pend_o gated by control bit 3.
- R9: A write of data bit 0 set to address 9 clears pend_o. A write of zero there leaves it unchanged. A frame end in the same cycle wins over the clear.
- R10: Writing control bit 2 raises swrst_busy_o for SWRST_CYCLES cycles, after which it clears itself. While it is high, output stops and writes are ignored. Afterwards every register holds its default of zero, including the control bits and the pending flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | CW | Register write data |
| hsync_o | output | 1 | Horizontal sync, active high |
| vsync_o | output | 1 | Vertical sync, active high |
| de_o | output | 1 | Data enable, high in the active region |
| x_o | output | CW | Active column |
| y_o | output | CW | Active row |
| irq_o | output | 1 | Frame interrupt (pending and enabled) |
| pend_o | output | 1 | Frame pending flag |
| stop_o | output | 1 | High while video is still running |
| swrst_busy_o | output | 1 | Software reset in progress |

## Verification
A phase counter that runs past its field, or a phase that is skipped, would move the sync and data-enable edges, and the per-pixel scoreboard would catch the misplaced edge within one line. A working copy of the registers that is refreshed mid-frame would change the line length before the frame boundary, and the compare would go wrong at the first pixel after the write. A wrong stop decision would show stop_o falling one cycle early or late against the expected idle items that follow the last frame. A reset that leaves a register stale would show up in the shape of the first frame that runs on default timing.

// File: rtl/vtg_pkg.sv
`timescale 1ns/1ps
package vtg_pkg;

  typedef enum logic [1:0] {
    PH_ACT  = 2'd0,
    PH_FP   = 2'd1,
    PH_SYNC = 2'd2,
    PH_BP   = 2'd3
  } phase_t;

  localparam int unsigned ADDR_W = 4;

  localparam logic [ADDR_W-1:0] A_CTRL   = 4'd0;
  localparam logic [ADDR_W-1:0] A_HACT   = 4'd1;
  localparam logic [ADDR_W-1:0] A_VACT   = 4'd2;
  localparam logic [ADDR_W-1:0] A_HFP    = 4'd3;
  localparam logic [ADDR_W-1:0] A_HSYNC  = 4'd4;
  localparam logic [ADDR_W-1:0] A_HBP    = 4'd5;
  localparam logic [ADDR_W-1:0] A_VFP    = 4'd6;
  localparam logic [ADDR_W-1:0] A_VSYNC  = 4'd7;
  localparam logic [ADDR_W-1:0] A_VBP    = 4'd8;
  localparam logic [ADDR_W-1:0] A_IRQCLR = 4'd9;

  localparam int CTRL_OUT = 0;
  localparam int CTRL_FRM = 1;
  localparam int CTRL_SWR = 2;
  localparam int CTRL_IRQ = 3;

  // fixed phase order of each axis
  function automatic phase_t next_phase(input phase_t p);
    case (p)
      PH_ACT:  next_phase = PH_FP;
      PH_FP:   next_phase = PH_SYNC;
      PH_SYNC: next_phase = PH_BP;
      default: next_phase = PH_ACT;
    endcase
  endfunction

endpackage

// File: rtl/vtg_axis.sv
`timescale 1ns/1ps
module vtg_axis
  import vtg_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               step,
  input  logic [3:0][CW-1:0] len_m1,
  output phase_t             phase,
  output logic [CW-1:0]      cnt,
  output logic               wrap
);

  logic at_end;

  assign at_end = (cnt == len_m1[phase]);
  assign wrap   = step && at_end && (phase == PH_BP);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      phase <= PH_ACT;
      cnt   <= '0;
    end else if (step) begin
      if (at_end) begin
        phase <= next_phase(phase);
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n) cnt <= len_m1[phase]); // R3

endmodule

// File: rtl/vtg_regs.sv
`timescale 1ns/1ps
module vtg_regs
  import vtg_pkg::*;
#(
  parameter int CW           = 12,
  parameter int SWRST_CYCLES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [CW-1:0]      wr_data,
  input  logic               frame_end,
  output logic               out_en,
  output logic               frm_en,
  output logic               irq_en,
  output logic [3:0][CW-1:0] h_len,
  output logic [3:0][CW-1:0] v_len,
  output logic               pending,
  output logic               busy
);

  localparam int RCW = $clog2(SWRST_CYCLES + 1);

  logic [RCW-1:0] rst_cnt;
  logic           wr_ok, swr_req, clr_req, rst_done;

  assign wr_ok    = wr_en && !busy;
  assign swr_req  = wr_ok && (wr_addr == A_CTRL) && wr_data[CTRL_SWR];
  assign clr_req  = wr_ok && (wr_addr == A_IRQCLR) && wr_data[0];
  assign rst_done = busy && (rst_cnt == RCW'(SWRST_CYCLES - 1));

  // field registers
  always_ff @(posedge clk) begin
    if (!rst_n || busy || swr_req) begin
      out_en <= 1'b0;
      frm_en <= 1'b0;
      irq_en <= 1'b0;
      h_len  <= '0;
      v_len  <= '0;
    end else if (wr_ok) begin
      case (wr_addr)
        A_CTRL: begin
          out_en <= wr_data[CTRL_OUT];
          frm_en <= wr_data[CTRL_FRM];
          irq_en <= wr_data[CTRL_IRQ];
        end
        A_HACT:  h_len[PH_ACT]  <= wr_data;
        A_HFP:   h_len[PH_FP]   <= wr_data;
        A_HSYNC: h_len[PH_SYNC] <= wr_data;
        A_HBP:   h_len[PH_BP]   <= wr_data;
        A_VACT:  v_len[PH_ACT]  <= wr_data;
        A_VFP:   v_len[PH_FP]   <= wr_data;
        A_VSYNC: v_len[PH_SYNC] <= wr_data;
        A_VBP:   v_len[PH_BP]   <= wr_data;
        default: ;
      endcase
    end
  end

  // self-clearing software reset
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rst_cnt <= '0;
    end else if (swr_req) begin
      busy    <= 1'b1;
      rst_cnt <= '0;
    end else if (busy) begin
      if (rst_done) busy <= 1'b0;
      else          rst_cnt <= rst_cnt + 1'b1;
    end
  end

  // frame pending flag: set wins over clear
  always_ff @(posedge clk) begin
    if (!rst_n || busy)  pending <= 1'b0;
    else if (frame_end)  pending <= 1'b1;
    else if (clr_req)    pending <= 1'b0;
  end

  AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) clr_req && !frame_end |=> !pending); // R9
  AST_RESET_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !pending && !out_en && !frm_en && !irq_en); // R10

endmodule

// File: rtl/vtg_top.sv
`timescale 1ns/1ps
module vtg_top
  import vtg_pkg::*;
#(
  parameter int CW           = 12,
  parameter int SWRST_CYCLES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [3:0]        wr_addr,
  input  logic [CW-1:0]     wr_data,
  output logic              hsync_o,
  output logic              vsync_o,
  output logic              de_o,
  output logic [CW-1:0]     x_o,
  output logic [CW-1:0]     y_o,
  output logic              irq_o,
  output logic              pend_o,
  output logic              stop_o,
  output logic              swrst_busy_o
);

  localparam int SW = CW + 2;
  localparam int FW = 2 * SW;

  // length of one axis in units, from its four minus-one fields
  function automatic logic [SW-1:0] span(input logic [3:0][CW-1:0] l);
    span = SW'(l[0]) + SW'(l[1]) + SW'(l[2]) + SW'(l[3]) + SW'(4);
  endfunction

  logic               out_en, frm_en, irq_en, pending, busy;
  logic [3:0][CW-1:0] h_len, v_len, sh_h, sh_v;
  logic               running, go_w, start_w, frame_end_w;
  logic               h_wrap, v_wrap;
  phase_t             h_ph, v_ph;
  logic [CW-1:0]      h_cnt, v_cnt;
  logic [FW-1:0]      fcnt, frame_len_w;

  vtg_regs #(.CW(CW), .SWRST_CYCLES(SWRST_CYCLES)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .frame_end (frame_end_w),
    .out_en    (out_en),
    .frm_en    (frm_en),
    .irq_en    (irq_en),
    .h_len     (h_len),
    .v_len     (v_len),
    .pending   (pending),
    .busy      (busy)
  );

  vtg_axis #(.CW(CW)) u_hax (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!running),
    .step   (running),
    .len_m1 (sh_h),
    .phase  (h_ph),
    .cnt    (h_cnt),
    .wrap   (h_wrap)
  );

  vtg_axis #(.CW(CW)) u_vax (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (!running),
    .step   (h_wrap),
    .len_m1 (sh_v),
    .phase  (v_ph),
    .cnt    (v_cnt),
    .wrap   (v_wrap)
  );

  assign go_w        = out_en && frm_en;
  assign frame_end_w = running && v_wrap;
  assign start_w     = go_w && !busy && (!running || frame_end_w);

  // run state and working copy of the timing
  always_ff @(posedge clk) begin
    if (!rst_n || busy)   running <= 1'b0;
    else if (start_w)     running <= 1'b1;
    else if (frame_end_w) running <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_h <= '0;
      sh_v <= '0;
    end else if (start_w) begin
      sh_h <= h_len;
      sh_v <= v_len;
    end
  end

  // cycles into the current frame, watched by the frame-length check
  assign frame_len_w = FW'(span(sh_h)) * FW'(span(sh_v));

  always_ff @(posedge clk) begin
    if (!rst_n)       fcnt <= '0;
    else if (start_w) fcnt <= '0;
    else if (running) fcnt <= fcnt + 1'b1;
  end

  assign hsync_o      = running && (h_ph == PH_SYNC);
  assign vsync_o      = running && (v_ph == PH_SYNC);
  assign de_o         = running && (h_ph == PH_ACT) && (v_ph == PH_ACT);
  assign x_o          = (h_ph == PH_ACT) ? h_cnt : '0;
  assign y_o          = (v_ph == PH_ACT) ? v_cnt : '0;
  assign irq_o        = pending && irq_en;
  assign pend_o       = pending;
  assign stop_o       = running;
  assign swrst_busy_o = busy;

  AST_DE_NO_SYNC: assert property (@(posedge clk) disable iff (!rst_n) de_o |-> !hsync_o && !vsync_o); // R5
  AST_RUN_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n) $rose(running) |-> $past(go_w)); // R2
  AST_STOP_ON_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n) $fell(running) |-> $past(frame_end_w) || $past(busy)); // R7
  AST_SHADOW_HOLD: assert property (@(posedge clk) disable iff (!rst_n) running && !frame_end_w |=> $stable(sh_h) && $stable(sh_v)); // R6
  AST_FRAME_LEN: assert property (@(posedge clk) disable iff (!rst_n) frame_end_w |-> fcnt == frame_len_w - 1'b1); // R4
  AST_SWRST_STOPS: assert property (@(posedge clk) disable iff (!rst_n) busy |=> !running); // R10

endmodule

// File: tb/vtg_top_test.sv
`timescale 1ns/1ps
module vtg_top_test;

  localparam int CW   = 12;
  localparam int NRST = 8;

  localparam logic [3:0] AD_CTRL = 4'd0, AD_HACT = 4'd1, AD_VACT = 4'd2,
    AD_HFP = 4'd3, AD_HSYNC = 4'd4, AD_HBP = 4'd5, AD_VFP = 4'd6,
    AD_VSYNC = 4'd7, AD_VBP = 4'd8, AD_CLR = 4'd9;

  typedef struct packed {
    logic          hs;
    logic          vs;
    logic          de;
    logic          stop;
    logic [CW-1:0] x;
    logic [CW-1:0] y;
  } item_t;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [CW-1:0] wr_data = '0;
  logic          hsync_o, vsync_o, de_o, irq_o, pend_o, stop_o, swrst_busy_o;
  logic [CW-1:0] x_o, y_o;

  int    total = 0;
  int    bad   = 0;
  logic  mon_en = 1'b0;
  item_t exp_q[$];

  always #4 clk = ~clk;

  vtg_top #(.CW(CW), .SWRST_CYCLES(NRST)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .de_o(de_o), .x_o(x_o), .y_o(y_o),
    .irq_o(irq_o), .pend_o(pend_o), .stop_o(stop_o), .swrst_busy_o(swrst_busy_o)
  );

  task automatic check(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [CW-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // driver side: expected raster for one frame, counts given as real lengths
  task automatic push_frame(input int ha, input int hf, input int hs, input int hb,
                            input int va, input int vf, input int vs, input int vb);
    item_t it;
    for (int l = 0; l < va + vf + vs + vb; l++) begin
      for (int p = 0; p < ha + hf + hs + hb; p++) begin
        it.hs   = (p >= ha + hf) && (p < ha + hf + hs);
        it.vs   = (l >= va + vf) && (l < va + vf + vs);
        it.de   = (p < ha) && (l < va);
        it.stop = 1'b1;
        it.x    = (p < ha) ? CW'(p) : '0;
        it.y    = (l < va) ? CW'(l) : '0;
        exp_q.push_back(it);
      end
    end
  endtask

  task automatic push_idle(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back('0);
  endtask

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    mon_en = 1'b0;
  endtask

  // monitor: one compare per cycle while items are queued (R3 R4 R5 R7)
  always @(negedge clk) begin
    if (mon_en && exp_q.size() != 0) begin
      item_t e, a;
      e = exp_q.pop_front();
      a = {hsync_o, vsync_o, de_o, stop_o, x_o, y_o};
      check(a == e, "R3 R4 R5 R6 R7 raster", 64'(a), 64'(e));
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check({hsync_o, vsync_o, de_o, irq_o, pend_o, stop_o, swrst_busy_o} == 7'b0, "R1 flags", 64'({hsync_o, vsync_o, de_o, irq_o, pend_o, stop_o, swrst_busy_o}), 64'd0);
    check(x_o == '0 && y_o == '0, "R1 coords", 64'({x_o, y_o}), 64'd0);

    // configuration A, lengths minus one: H 8/2/3/4, V 4/1/2/2
    reg_wr(AD_HACT, 12'd7);  reg_wr(AD_HFP, 12'd1);  reg_wr(AD_HSYNC, 12'd2); reg_wr(AD_HBP, 12'd3);
    reg_wr(AD_VACT, 12'd3);  reg_wr(AD_VFP, 12'd0);  reg_wr(AD_VSYNC, 12'd1); reg_wr(AD_VBP, 12'd1);

    // R2: one enable alone starts nothing
    reg_wr(AD_CTRL, 12'b1001);
    repeat (30) @(negedge clk);
    check(stop_o == 1'b0 && de_o == 1'b0, "R2 output enable alone", 64'({stop_o, de_o}), 64'd0);
    reg_wr(AD_CTRL, 12'b0010);
    repeat (10) @(negedge clk);
    check(stop_o == 1'b0 && hsync_o == 1'b0, "R2 frame enable alone", 64'({stop_o, hsync_o}), 64'd0);

    // frame A, then frame B with a new active width written mid-frame (R6), then stop (R7)
    push_frame(8, 2, 3, 4, 4, 1, 2, 2);
    push_frame(6, 2, 3, 4, 4, 1, 2, 2);
    push_idle(5);
    reg_wr(AD_CTRL, 12'b1011);
    @(posedge clk);
    mon_en = 1'b1;
    repeat (40) @(negedge clk);
    check(pend_o == 1'b0, "R8 no pending mid-frame", 64'(pend_o), 64'd0);
    reg_wr(AD_HACT, 12'd5);
    repeat (150) @(negedge clk);
    check(pend_o == 1'b1, "R8 pending after frame end", 64'(pend_o), 64'd1);
    check(irq_o == 1'b1, "R8 irq enabled", 64'(irq_o), 64'd1);
    reg_wr(AD_CTRL, 12'b1001);
    drain();
    check(stop_o == 1'b0, "R7 stopped after frame", 64'(stop_o), 64'd0);

    // R9 pending clear
    reg_wr(AD_CLR, 12'd0);
    check(pend_o == 1'b1, "R9 write zero keeps pending", 64'(pend_o), 64'd1);
    reg_wr(AD_CLR, 12'd1);
    check(pend_o == 1'b0, "R9 write one clears", 64'(pend_o), 64'd0);
    check(irq_o == 1'b0, "R8 irq follows pending", 64'(irq_o), 64'd0);

    // R10 software reset while running
    reg_wr(AD_CTRL, 12'b0011);
    repeat (20) @(negedge clk);
    check(stop_o == 1'b1, "R2 running", 64'(stop_o), 64'd1);
    reg_wr(AD_CTRL, 12'b0100);
    check(swrst_busy_o == 1'b1, "R10 busy raised", 64'(swrst_busy_o), 64'd1);
    repeat (NRST - 1) @(negedge clk);
    check(swrst_busy_o == 1'b1, "R10 busy last cycle", 64'(swrst_busy_o), 64'd1);
    check(stop_o == 1'b0 && pend_o == 1'b0, "R10 halted and cleared", 64'({stop_o, pend_o}), 64'd0);
    @(negedge clk);
    check(swrst_busy_o == 1'b0, "R10 busy self-cleared", 64'(swrst_busy_o), 64'd0);

    // R10 defaults: every field zero means one unit per phase
    push_frame(1, 1, 1, 1, 1, 1, 1, 1);
    push_idle(3);
    reg_wr(AD_CTRL, 12'b0011);
    @(posedge clk);
    mon_en = 1'b1;
    reg_wr(AD_CTRL, 12'b0000);
    drain();
    check(pend_o == 1'b1, "R8 pending after default frame", 64'(pend_o), 64'd1);
    check(irq_o == 1'b0, "R8 irq masked by reset default", 64'(irq_o), 64'd0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule